// File: doc/BRIEF.md
# Zero-Gated Cascaded Multiply-Accumulate Array

This block is the arithmetic core of a one-dimensional convolution engine for a small CNN. It has a grid of processing elements (PEs). There are `NCH` rows, one for each output channel, and `NTAP` PEs in each row, one for each kernel tap. Each PE holds a signed weight and a private saturating accumulator. Samples enter as a valid/ready stream. Every PE checks the sign bit of the sample that reaches it and treats a negative value as zero, which is a rectifier that needs no comparator. Inside each row, each PE hands its rectified sample to the next PE on the next accepted beat. Tap `k` therefore always works on the sample that arrived `k` beats earlier. Rows and taps compute at the same time, and a new sample can be taken every cycle.

A PE that receives a zero operand does not use its multiplier. The operand registers keep their last non-zero pair, the accumulator stays as it is, and a free-running counter records the event. The output stream carries the saturated sum of each row's accumulators. A caller controls the length of each accumulation with `clear_acc` and `in_last`:

- Clearing on every beat gives a sliding dot product, one result per cycle.
- Leaving the accumulators uncleared adds up a series of beats, for example one per input channel, into a single result.

Top module: `zg_mac_array`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `skip_count` is 0, every row sum on `out_data` is 0, and every stored sample and weight is 0.
- R2: A beat is accepted in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly while `out_valid` is 1 and `out_ready` is 0. A beat that is not accepted changes nothing.
- R3: On each accepted beat, tap `k` of every row works on the sample accepted `k` beats earlier, counting the current beat as 0. Taps whose sample does not exist yet use 0.
- R4: A sample with its most significant bit set (a negative two's-complement value) is treated as 0 by every PE.
- R5: On each accepted beat, PE (c,k) adds `w[c][k] * sample_k` to its accumulator, using signed 8-bit operands. Row c's result is the sum of its `NTAP` accumulators and appears on `out_data[c*ACC_W +: ACC_W]`.
- R6: If `clear_acc` is 1 together with an accepted beat, every accumulator restarts from that beat's products. If `clear_acc` is 1 with no beat and `in_ready` is 1, every accumulator becomes 0. If `in_ready` is 0, `clear_acc` is ignored.
- R7: `out_valid` rises in the cycle after an accepted beat that has `in_last` set. It then stays 1, with `out_data` stable, until a cycle in which `out_ready` is 1.
- R8: Each PE accumulator saturates at the 24-bit signed limits. Each row sum is formed exactly and then saturated to the same limits.
- R9: On an accepted beat, a PE whose operand is 0 leaves its accumulator unchanged. On that beat, `skip_count` grows by the number of such PEs and wraps modulo 2^16.
- R10: A cycle with `w_we` set writes `w_data` into PE (`w_row`, `w_tap`). Tap 0 is the PE that sees the newest sample. A write to a tap index of `NTAP` or above has no effect.
- R11: While no beat is accepted, the accumulators, the stored samples and `skip_count` keep their values, whatever is on `in_data` and `in_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample beat offered |
| in_ready | output | 1 | Array can take a beat |
| in_data | input | 8 | Signed pre-activation sample |
| in_last | input | 1 | Beat closes the current accumulation |
| clear_acc | input | 1 | Restart all accumulators |
| w_we | input | 1 | Weight write strobe |
| w_row | input | 2 | Weight row (output channel) |
| w_tap | input | 3 | Weight tap index |
| w_data | input | 8 | Signed weight value |
| out_valid | output | 1 | Row sums are presented |
| out_ready | input | 1 | Consumer takes the row sums |
| out_data | output | 96 | Row sums, row c at bits c*24 and up |
| skip_count | output | 16 | Running count of gated multiplies |

## Verification
The checker assumes that a beat counts only when `in_valid` and `in_ready` are both high and that `in_data` carries a known value in that cycle. It also assumes that `out_ready` is never unknown. Given this, the properties on stalling, output stability and counter growth can depend only on the handshake pins. The bench drives every input on the falling clock edge and holds a blocked beat steady until the array accepts it. It keeps `out_ready` at a defined 0 or 1 and never pulls a beat back while it is being refused.

// File: rtl/zg_pkg.sv
package zg_pkg;

  localparam int ACT_W_DEF = 8;
  localparam int ACC_W_DEF = 24;
  localparam int CNT_W_DEF = 16;

  // Clamp a wide signed value into the range of a w-bit signed number.
  function automatic longint sat_to(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/zg_pe.sv
module zg_pe #(
  parameter int ACT_W = 8,
  parameter int ACC_W = 24,
  parameter bit HEAD  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    clr,
  input  logic signed [ACT_W-1:0] act_in,
  input  logic signed [ACT_W-1:0] w_in,
  output logic signed [ACT_W-1:0] op_out,
  output logic signed [ACC_W-1:0] acc_out
);

  localparam int PROD_W = 2 * ACT_W;

  logic signed [ACT_W-1:0]  src;
  logic signed [ACT_W-1:0]  op_pos;
  logic signed [ACT_W-1:0]  opa, opb, opa_q, opb_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  base, acc_q, acc_d;
  logic                     nz;

  // The head PE works on the live input sample. Every later PE works on
  // what its upstream neighbour used on the previous accepted beat.
  if (HEAD) begin : g_head
    assign src = act_in;
  end else begin : g_link
    logic signed [ACT_W-1:0] link_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    link_q <= '0;
      else if (step) link_q <= act_in;
    end
    assign src = link_q;
  end

  always_comb begin
    // Sign-bit rectifier: a set MSB forces the operand to zero.
    op_pos = src[ACT_W-1] ? '0 : src;
    nz     = |op_pos;
    // Zero gating: the multiplier keeps its last non-zero operands.
    opa    = nz ? op_pos : opa_q;
    opb    = nz ? w_in   : opb_q;
    prod   = opa * opb;
    base   = clr ? '0 : acc_q;
    acc_d  = ACC_W'(zg_pkg::sat_to(longint'(base) + longint'(prod), ACC_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
      acc_q <= '0;
    end else begin
      if (step && nz) begin
        opa_q <= opa;
        opb_q <= opb;
        acc_q <= acc_d;
      end else if (clr) begin
        acc_q <= '0;
      end
    end
  end

  assign op_out  = op_pos;
  assign acc_out = acc_q;

endmodule

// File: rtl/zg_row.sv
module zg_row #(
  parameter int NTAP  = 5,
  parameter int ACT_W = 8,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    clr,
  input  logic signed [ACT_W-1:0] act_in,
  input  logic [NTAP*ACT_W-1:0]   w_vec,
  output logic signed [ACC_W-1:0] row_sum,
  output logic [NTAP-1:0]         gate_vec
);

  localparam int SUM_W = ACC_W + $clog2(NTAP) + 1;

  logic signed [ACT_W-1:0] ops  [NTAP];
  logic signed [ACC_W-1:0] accs [NTAP];
  logic signed [SUM_W-1:0] total;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    logic signed [ACT_W-1:0] feed;
    if (k == 0) begin : g_first
      assign feed = act_in;
    end else begin : g_rest
      assign feed = ops[k-1];
    end

    zg_pe #(
      .ACT_W(ACT_W),
      .ACC_W(ACC_W),
      .HEAD (k == 0)
    ) u_pe (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .clr    (clr),
      .act_in (feed),
      .w_in   (w_vec[k*ACT_W +: ACT_W]),
      .op_out (ops[k]),
      .acc_out(accs[k])
    );

    assign gate_vec[k] = step && (ops[k] == '0);
  end

  // Exact wide sum of the tap accumulators, then one saturation.
  always_comb begin
    total = '0;
    for (int k = 0; k < NTAP; k++) total += SUM_W'(accs[k]);
    row_sum = ACC_W'(zg_pkg::sat_to(longint'(total), ACC_W));
  end

endmodule

// File: rtl/zg_wbank.sv
module zg_wbank #(
  parameter int NCH   = 4,
  parameter int NTAP  = 5,
  parameter int ACT_W = 8,
  parameter int RW    = 2,
  parameter int TW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [RW-1:0]             row,
  input  logic [TW-1:0]             tap,
  input  logic [ACT_W-1:0]          data,
  output logic [NCH*NTAP*ACT_W-1:0] weights
);

  for (genvar c = 0; c < NCH; c++) begin : g_row
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      logic [ACT_W-1:0] w_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          w_q <= '0;
        else if (we && row == RW'(c) && tap == TW'(k))
          w_q <= data;
      end
      assign weights[(c*NTAP + k)*ACT_W +: ACT_W] = w_q;
    end
  end

endmodule

// File: rtl/zg_mac_array.sv
module zg_mac_array #(
  parameter int NCH   = 4,
  parameter int NTAP  = 5,
  parameter int ACT_W = zg_pkg::ACT_W_DEF,
  parameter int ACC_W = zg_pkg::ACC_W_DEF,
  parameter int CNT_W = zg_pkg::CNT_W_DEF,
  localparam int RW   = (NCH  > 1) ? $clog2(NCH)  : 1,
  localparam int TW   = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ACT_W-1:0]     in_data,
  input  logic                 in_last,
  input  logic                 clear_acc,
  input  logic                 w_we,
  input  logic [RW-1:0]        w_row,
  input  logic [TW-1:0]        w_tap,
  input  logic [ACT_W-1:0]     w_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NCH*ACC_W-1:0] out_data,
  output logic [CNT_W-1:0]     skip_count
);

  localparam int NPE = NCH * NTAP;

  logic                      step;
  logic                      clr_eff;
  logic                      ov_q;
  logic [CNT_W-1:0]          skip_q;
  logic [NPE*ACT_W-1:0]      wflat;
  logic [NPE-1:0]            gates;

  // While a result waits for its consumer, the array is frozen.
  assign in_ready = !ov_q || out_ready;
  assign step     = in_valid && in_ready;
  assign clr_eff  = clear_acc && in_ready;

  zg_wbank #(
    .NCH  (NCH),
    .NTAP (NTAP),
    .ACT_W(ACT_W),
    .RW   (RW),
    .TW   (TW)
  ) u_wbank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (w_we),
    .row    (w_row),
    .tap    (w_tap),
    .data   (w_data),
    .weights(wflat)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zg_row #(
      .NTAP (NTAP),
      .ACT_W(ACT_W),
      .ACC_W(ACC_W)
    ) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .clr     (clr_eff),
      .act_in  (in_data),
      .w_vec   (wflat[c*NTAP*ACT_W +: NTAP*ACT_W]),
      .row_sum (out_data[c*ACC_W +: ACC_W]),
      .gate_vec(gates[c*NTAP +: NTAP])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      skip_q <= '0;
    end else begin
      if (step && in_last) ov_q <= 1'b1;
      else if (out_ready)  ov_q <= 1'b0;
      if (step) skip_q <= skip_q + CNT_W'($countones(gates));
    end
  end

  assign out_valid  = ov_q;
  assign skip_count = skip_q;

endmodule

// File: rtl/zg_mac_array_chk.sv
module zg_mac_array_chk #(
  parameter int NCH   = 4,
  parameter int NTAP  = 5,
  parameter int ACT_W = 8,
  parameter int ACC_W = 24,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [ACT_W-1:0]     in_data,
  input logic                 in_last,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NCH*ACC_W-1:0] out_data,
  input logic [CNT_W-1:0]     skip_count
);

  localparam int NPE = NCH * NTAP;

  // R2: a held result blocks new beats
  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: an unacknowledged result stays presented and unchanged
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: a result only appears after an accepted closing beat
  assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

  // R11: no accepted beat, no counter movement
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(skip_count));

  // R9: at most one gated multiply per PE on a beat
  assert_gate_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (CNT_W'(skip_count - $past(skip_count)) <= CNT_W'(NPE)));

  // R4: a negative sample gates at least the head PE of every row
  assert_relu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[ACT_W-1]) |=>
      (CNT_W'(skip_count - $past(skip_count)) >= CNT_W'(NCH)));

endmodule

bind zg_mac_array zg_mac_array_chk #(
  .NCH  (NCH),
  .NTAP (NTAP),
  .ACT_W(ACT_W),
  .ACC_W(ACC_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .skip_count(skip_count)
);

// File: tb/zg_mac_array_bench.sv
module zg_mac_array_bench;

  localparam int NCH   = 4;
  localparam int NTAP  = 5;
  localparam int ACC_W = 24;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [7:0]           in_data = '0;
  logic                 in_last = 1'b0;
  logic                 clear_acc = 1'b0;
  logic                 w_we = 1'b0;
  logic [1:0]           w_row = '0;
  logic [2:0]           w_tap = '0;
  logic [7:0]           w_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [NCH*ACC_W-1:0] out_data;
  logic [15:0]          skip_count;

  always #5 clk = ~clk;

  zg_mac_array u_zg_mac_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .clear_acc(clear_acc),
    .w_we(w_we), .w_row(w_row), .w_tap(w_tap), .w_data(w_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .skip_count(skip_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint      w_m   [NCH][NTAP];
  longint      acc_m [NCH][NTAP];
  longint      hist  [NTAP];
  logic [15:0] skip_m = '0;

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint row_exp(input int c);
    longint s = 0;
    for (int k = 0; k < NTAP; k++) s += acc_m[c][k];
    return sat24(s);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_rows(input string req);
    for (int c = 0; c < NCH; c++) begin
      longint got = longint'($signed(out_data[c*ACC_W +: ACC_W]));
      chk(got == row_exp(c), req, $sformatf("row %0d sum", c), got, row_exp(c));
    end
  endtask

  task automatic check_skip(input string req);
    chk(skip_count == skip_m, req, "skip_count", longint'(skip_count), longint'(skip_m));
  endtask

  // Reference behaviour of one accepted beat, from the requirements.
  task automatic model_beat(input longint x, input bit clr);
    int zeros = 0;
    for (int k = NTAP - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = (x < 0) ? 0 : x;
    for (int k = 0; k < NTAP; k++) if (hist[k] == 0) zeros++;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NTAP; k++) begin
        if (clr) acc_m[c][k] = 0;
        if (hist[k] != 0) acc_m[c][k] = sat24(acc_m[c][k] + w_m[c][k] * hist[k]);
      end
    skip_m = skip_m + 16'(NCH * zeros);
  endtask

  // Called at a falling edge with the consumer ready.
  task automatic drive_beat(input longint x, input bit clr, input bit last);
    in_valid  = 1'b1;
    in_data   = 8'(x);
    in_last   = last;
    clear_acc = clr;
    @(negedge clk);
    model_beat(x, clr);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    clear_acc = 1'b0;
  endtask

  task automatic wload(input int r, input int t, input longint v);
    w_we = 1'b1; w_row = 2'(r); w_tap = 3'(t); w_data = 8'(v);
    @(negedge clk);
    w_we = 1'b0;
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);
    chk(skip_count == 16'd0, "R1", "skip_count", longint'(skip_count), 0);
    check_rows("R1");
  endtask

  task automatic t_weights;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NTAP; k++) begin
        w_m[c][k] = longint'((c * 7 + k * 5) % 23) - 11;
        wload(c, k, w_m[c][k]);
      end
    // R10: tap indices past the last PE must not land anywhere
    wload(0, 5, 100);
    wload(2, 7, -100);
    drive_beat(10, 1'b1, 1'b1);
    chk(out_valid == 1'b1, "R10", "out_valid", longint'(out_valid), 1);
    check_rows("R10");
  endtask

  task automatic t_stream;
    longint xs [12] = '{5, -3, 0, 17, -128, 127, 9, 0, 0, -1, 44, 2};
    foreach (xs[i]) begin
      drive_beat(xs[i], 1'b1, 1'b1);
      chk(out_valid == 1'b1, "R3", "out_valid per beat", longint'(out_valid), 1);
      check_rows(xs[i] < 0 ? "R4" : "R3");
    end
    check_skip("R9");
  endtask

  task automatic t_accum;
    drive_beat(3, 1'b1, 1'b0);
    drive_beat(-7, 1'b0, 1'b0);
    drive_beat(60, 1'b0, 1'b0);
    chk(out_valid == 1'b0, "R7", "out_valid before last", longint'(out_valid), 0);
    drive_beat(0, 1'b0, 1'b0);
    drive_beat(25, 1'b0, 1'b0);
    drive_beat(-90, 1'b0, 1'b1);
    chk(out_valid == 1'b1, "R7", "out_valid after last", longint'(out_valid), 1);
    check_rows("R5");
    check_skip("R9");
  endtask

  task automatic t_clear_idle;
    clear_acc = 1'b1;
    @(negedge clk);
    clear_acc = 1'b0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NTAP; k++) acc_m[c][k] = 0;
    check_rows("R6");
    drive_beat(7, 1'b0, 1'b1);
    check_rows("R6");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    drive_beat(20, 1'b1, 1'b1);
    chk(out_valid == 1'b1, "R7", "out_valid raised", longint'(out_valid), 1);
    chk(in_ready == 1'b0, "R2", "in_ready stalled", longint'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'd99; clear_acc = 1'b1; in_last = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R7", "out_valid held", longint'(out_valid), 1);
      chk(in_ready == 1'b0, "R2", "in_ready held low", longint'(in_ready), 0);
      check_rows("R6");
    end
    check_skip("R2");
    out_ready = 1'b1;
    @(negedge clk);
    model_beat(99, 1'b1);
    in_valid = 1'b0; clear_acc = 1'b0; in_last = 1'b0;
    chk(out_valid == 1'b1, "R2", "out_valid for released beat", longint'(out_valid), 1);
    check_rows("R2");
    check_skip("R2");
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "out_valid dropped", longint'(out_valid), 0);
    for (int i = 0; i < 5; i++) begin
      in_data = 8'(i * 37 - 90);
      in_last = 1'b1;
      @(negedge clk);
    end
    in_last = 1'b0;
    chk(out_valid == 1'b0, "R11", "out_valid idle", longint'(out_valid), 0);
    check_skip("R11");
    check_rows("R11");
    drive_beat(0, 1'b0, 1'b1);
    check_rows("R11");
  endtask

  task automatic t_sat;
    for (int k = 0; k < NTAP; k++) begin
      w_m[0][k] = 127;
      w_m[1][k] = (k == 0) ? 127 : ((k == 1) ? -128 : 0);
      w_m[2][k] = -128;
      w_m[3][k] = (k == 4) ? 1 : 0;
      for (int c = 0; c < NCH; c++) wload(c, k, w_m[c][k]);
    end
    for (int i = 0; i < 700; i++) drive_beat(127, i == 0, i == 699);
    check_rows("R8");
    chk(row_exp(1) == -1, "R8", "per-PE clamp reference", row_exp(1), -1);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 3400; i++) drive_beat(0, 1'b0, i == 3399);
    check_skip("R9");
    check_rows("R9");
  endtask

  initial begin
    for (int k = 0; k < NTAP; k++) hist[k] = 0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NTAP; k++) begin
        w_m[c][k] = 0;
        acc_m[c][k] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_weights();
    t_stream();
    t_accum();
    t_clear_idle();
    t_backpressure();
    t_idle();
    t_sat();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule